// File: doc/BRIEF.md
# Round-Robin Serial Link Request Spreader

This block takes requests from one upstream requester and deals them out across `N_LINKS` downstream serial-link request channels in strict rotation. Every request carries an identifier, a data-present flag, a payload size in bytes and a flag saying whether it expects a reply. Each downstream channel is modelled as a resource that stays occupied for a while after it takes a request. When the channel that is next in rotation is occupied, or when it refuses the request, the upstream side sees `up_ready` low and must try again.

The rotation index moves on by one in every cycle that `up_valid` is high, whether or not the request is taken. A retry is therefore aimed at the next channel, not the one that refused it. Each channel runs a small state machine with three states. `L_FREE` means it can take a request. `L_BACKOFF` is a one-cycle hold entered after a refusal. `L_XFER` is a payload hold that counts down. The transitions are: FREE to XFER when a send is accepted; FREE to BACKOFF when a send is refused; BACKOFF to FREE unconditionally; XFER to FREE when the count reaches its last cycle; XFER back to XFER otherwise.

For each accepted request that needs a reply and is not answered by another agent, the block stores the identifier in a small associative table. A reply can later look up the identifier to confirm the route, and the lookup frees the entry. Each channel keeps a packet count and a byte count.

Top module: `link_spreader`

## Requirements
- R1: After reset the rotation index is 0 and every channel is free. All packet and byte counters read 0, the route table is empty (`rsp_hit` low for every identifier), and both error pulses are low.
- R2: While `up_valid` is high and the target channel is free, `dn_valid` has exactly one bit set, at the index of the target channel. `dn_id` carries `up_id`. `dn_size` carries the effective size, which is `up_size` when `up_has_data` is 1 and 0 otherwise.
- R3: The target channel is the current rotation index. The index increments in every cycle that `up_valid` is high and wraps from `N_LINKS-1` to 0. In every other cycle it holds its value.
- R4: If the target channel is not free, `up_ready` is low and `dn_valid` is all zero.
- R5: If the target channel is free, `up_ready` equals that channel's `dn_ready` bit.
- R6: When a free channel is offered a request and its `dn_ready` is low, that channel is unavailable for exactly the next cycle.
- R7: When a channel accepts a request, it is unavailable for the next 1 + ceil(effective size / `LINK_BPC`) cycles.
- R8: An accepted request increments its channel's packet count by 1 and adds the effective size to its byte count. A refused request changes no counter. Channel `l` occupies bits `[l*CNT_W +: CNT_W]` of `pkt_cnt` and of `byte_cnt`.
- R9: An accepted request with `up_needs_rsp`=1 and `up_other_resp`=0 records its identifier. No other request records an identifier. With `rsp_valid` high, `rsp_hit` is high in the same cycle exactly when `rsp_id` is recorded, and that entry is freed at the next edge.
- R10: Recording an identifier that is already in the table stores nothing new and raises `err_dup` for the one cycle after the edge.
- R11: Recording a new identifier while all `RT_DEPTH` entries are in use stores nothing and raises `err_full` for the one cycle after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_valid | input | 1 | Upstream request present |
| up_ready | output | 1 | Upstream request accepted this cycle |
| up_id | input | ID_W | Request identifier |
| up_has_data | input | 1 | Request carries a payload |
| up_size | input | SIZE_W | Payload size in bytes |
| up_needs_rsp | input | 1 | Request expects a reply |
| up_other_resp | input | 1 | Another agent will answer this request |
| dn_valid | output | N_LINKS | One-hot offer to the target channel |
| dn_ready | input | N_LINKS | Per-channel acceptance |
| dn_id | output | ID_W | Identifier forwarded to channels |
| dn_size | output | SIZE_W | Effective size forwarded to channels |
| rsp_valid | input | 1 | Reply lookup strobe |
| rsp_id | input | ID_W | Identifier of the reply |
| rsp_hit | output | 1 | Reply identifier found in the route table |
| err_dup | output | 1 | Duplicate identifier pulse |
| err_full | output | 1 | Route table full pulse |
| pkt_cnt | output | N_LINKS*CNT_W | Per-channel packet counts |
| byte_cnt | output | N_LINKS*CNT_W | Per-channel byte counts |

## Verification
The bench builds the block with three channels, four bytes per cycle, a five-bit size and a two-entry route table. Three channels make the wrap point a value that is not a power of two. The bench sweeps every size from 0 to 31, with and without data, against all eight `dn_ready` patterns, so every hold length from one to nine cycles and every mix of refusal, occupancy and acceptance shows up on every channel. The two-entry table fills after just two records, which puts the duplicate, full, not-recorded and free-on-lookup cases within a few directed sends.

// File: rtl/link_spreader_pkg.sv
package link_spreader_pkg;
    typedef enum logic [1:0] {
        L_FREE    = 2'd0,
        L_BACKOFF = 2'd1,
        L_XFER    = 2'd2
    } link_state_e;
endpackage

// File: rtl/rr_pointer.sv
module rr_pointer #(
    parameter int N_LINKS = 4,
    localparam int IW = (N_LINKS > 1) ? $clog2(N_LINKS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          advance,
    output logic [IW-1:0] idx
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (advance) begin
            if (idx == IW'(N_LINKS - 1)) idx <= '0;
            else                         idx <= idx + IW'(1);
        end
    end
endmodule

// File: rtl/link_slot.sv
module link_slot
    import link_spreader_pkg::*;
#(
    parameter int BUSY_W = 6,
    parameter int SIZE_W = 5,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              offer,
    input  logic              sent,
    input  logic [BUSY_W-1:0] hold_load,
    input  logic [SIZE_W-1:0] eff_size,
    output logic              avail,
    output logic [CNT_W-1:0]  pkt_cnt,
    output logic [CNT_W-1:0]  byte_cnt
);
    link_state_e       st, st_nxt;
    logic [BUSY_W-1:0] cnt, cnt_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= L_FREE;
            cnt <= '0;
        end else begin
            st  <= st_nxt;
            cnt <= cnt_nxt;
        end
    end

    always_comb begin
        st_nxt  = st;
        cnt_nxt = cnt;
        unique case (st)
            L_FREE: begin
                if (sent) begin
                    st_nxt  = L_XFER;
                    cnt_nxt = hold_load;
                end else if (offer) begin
                    st_nxt  = L_BACKOFF;
                end
            end
            L_BACKOFF: st_nxt = L_FREE;
            L_XFER: begin
                if (cnt <= BUSY_W'(1)) begin
                    st_nxt  = L_FREE;
                    cnt_nxt = '0;
                end else begin
                    cnt_nxt = cnt - BUSY_W'(1);
                end
            end
            default: st_nxt = L_FREE;
        endcase
    end

    always_comb avail = (st == L_FREE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_cnt  <= '0;
            byte_cnt <= '0;
        end else if (sent) begin
            pkt_cnt  <= pkt_cnt + CNT_W'(1);
            byte_cnt <= byte_cnt + CNT_W'(eff_size);
        end
    end
endmodule

// File: rtl/route_cam.sv
module route_cam #(
    parameter int ID_W  = 4,
    parameter int DEPTH = 4,
    localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rec_en,
    input  logic [ID_W-1:0] rec_id,
    input  logic            rsp_valid,
    input  logic [ID_W-1:0] rsp_id,
    output logic            rsp_hit,
    output logic            err_dup,
    output logic            err_full
);
    logic [DEPTH-1:0]  vld;
    logic [ID_W-1:0]   ids [DEPTH];
    logic [DEPTH-1:0]  rsp_match, rec_match;
    logic [SLOT_W-1:0] slot;
    logic              found, dup, full, do_rec;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            rsp_match[i] = vld[i] && (ids[i] == rsp_id);
            rec_match[i] = vld[i] && (ids[i] == rec_id);
        end
    end

    always_comb begin
        slot  = '0;
        found = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!vld[i] && !found) begin
                slot  = SLOT_W'(i);
                found = 1'b1;
            end
        end
    end

    assign rsp_hit = rsp_valid && (|rsp_match);
    assign dup     = |rec_match;
    assign full    = &vld;
    assign do_rec  = rec_en && !dup && !full;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld      <= '0;
            err_dup  <= 1'b0;
            err_full <= 1'b0;
            for (int i = 0; i < DEPTH; i++) ids[i] <= '0;
        end else begin
            err_dup  <= rec_en && dup;
            err_full <= rec_en && !dup && full;
            for (int i = 0; i < DEPTH; i++) begin
                if (rsp_valid && rsp_match[i]) vld[i] <= 1'b0;
            end
            if (do_rec) begin
                vld[slot] <= 1'b1;
                ids[slot] <= rec_id;
            end
        end
    end
endmodule

// File: rtl/link_spreader.sv
module link_spreader #(
    parameter int N_LINKS  = 4,
    parameter int ID_W     = 4,
    parameter int SIZE_W   = 6,
    parameter int LINK_BPC = 4,
    parameter int RT_DEPTH = 4,
    parameter int CNT_W    = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     up_valid,
    output logic                     up_ready,
    input  logic [ID_W-1:0]          up_id,
    input  logic                     up_has_data,
    input  logic [SIZE_W-1:0]        up_size,
    input  logic                     up_needs_rsp,
    input  logic                     up_other_resp,
    output logic [N_LINKS-1:0]       dn_valid,
    input  logic [N_LINKS-1:0]       dn_ready,
    output logic [ID_W-1:0]          dn_id,
    output logic [SIZE_W-1:0]        dn_size,
    input  logic                     rsp_valid,
    input  logic [ID_W-1:0]          rsp_id,
    output logic                     rsp_hit,
    output logic                     err_dup,
    output logic                     err_full,
    output logic [N_LINKS*CNT_W-1:0] pkt_cnt,
    output logic [N_LINKS*CNT_W-1:0] byte_cnt
);
    localparam int IW     = (N_LINKS > 1) ? $clog2(N_LINKS) : 1;
    localparam int BUSY_W = SIZE_W + 1;

    logic [IW-1:0]      rr_idx;
    logic [N_LINKS-1:0] avail;
    logic               tgt_free, rec_en;
    logic [SIZE_W-1:0]  eff_size;
    logic [BUSY_W-1:0]  beats, hold_load;

    rr_pointer #(.N_LINKS(N_LINKS)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (up_valid),
        .idx     (rr_idx)
    );

    always_comb begin
        eff_size  = up_has_data ? up_size : '0;
        beats     = (BUSY_W'(eff_size) + BUSY_W'(LINK_BPC - 1)) / BUSY_W'(LINK_BPC);
        hold_load = beats + BUSY_W'(1);
        tgt_free  = avail[rr_idx];
        dn_valid  = '0;
        if (up_valid && tgt_free) dn_valid[rr_idx] = 1'b1;
        up_ready  = up_valid && tgt_free && dn_ready[rr_idx];
        dn_id     = up_id;
        dn_size   = eff_size;
        rec_en    = up_ready && up_needs_rsp && !up_other_resp;
    end

    for (genvar l = 0; l < N_LINKS; l++) begin : g_link
        link_slot #(
            .BUSY_W (BUSY_W),
            .SIZE_W (SIZE_W),
            .CNT_W  (CNT_W)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .offer     (dn_valid[l]),
            .sent      (dn_valid[l] && dn_ready[l]),
            .hold_load (hold_load),
            .eff_size  (eff_size),
            .avail     (avail[l]),
            .pkt_cnt   (pkt_cnt[l*CNT_W +: CNT_W]),
            .byte_cnt  (byte_cnt[l*CNT_W +: CNT_W])
        );
    end

    route_cam #(.ID_W(ID_W), .DEPTH(RT_DEPTH)) u_cam (
        .clk       (clk),
        .rst_n     (rst_n),
        .rec_en    (rec_en),
        .rec_id    (up_id),
        .rsp_valid (rsp_valid),
        .rsp_id    (rsp_id),
        .rsp_hit   (rsp_hit),
        .err_dup   (err_dup),
        .err_full  (err_full)
    );
endmodule

// File: rtl/link_spreader_chk.sv
module link_spreader_chk #(
    parameter int N_LINKS = 4,
    localparam int IW = (N_LINKS > 1) ? $clog2(N_LINKS) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               up_valid,
    input logic               up_ready,
    input logic [N_LINKS-1:0] dn_valid,
    input logic [N_LINKS-1:0] dn_ready,
    input logic [IW-1:0]      rr_idx
);
    // R2
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dn_valid));

    // R5
    ready_backed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_ready |-> (up_valid && ((dn_valid & dn_ready) != '0)));

    // R3
    rr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid |=> (rr_idx == (($past(rr_idx) == IW'(N_LINKS - 1)) ? '0 : $past(rr_idx) + IW'(1))));

    // R3
    rr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !up_valid |=> $stable(rr_idx));

    // R6 R7
    no_reoffer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid != '0) |=> ((dn_valid & $past(dn_valid)) == '0));
endmodule

bind link_spreader link_spreader_chk #(.N_LINKS(N_LINKS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (up_valid),
    .up_ready (up_ready),
    .dn_valid (dn_valid),
    .dn_ready (dn_ready),
    .rr_idx   (rr_idx)
);

// File: tb/sim_link_spreader.sv
module sim_link_spreader;
    localparam int N   = 3;
    localparam int IDW = 4;
    localparam int SW  = 5;
    localparam int BPC = 4;
    localparam int DEP = 2;
    localparam int CW  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic up_valid = 1'b0, up_ready, up_has_data = 1'b0, up_needs_rsp = 1'b0, up_other_resp = 1'b0;
    logic [IDW-1:0] up_id = '0, dn_id, rsp_id = '0;
    logic [SW-1:0]  up_size = '0, dn_size;
    logic [N-1:0]   dn_valid, dn_ready = '1;
    logic rsp_valid = 1'b0, rsp_hit, err_dup, err_full;
    logic [N*CW-1:0] pkt_cnt, byte_cnt;

    always #5 clk = ~clk;

    link_spreader #(.N_LINKS(N), .ID_W(IDW), .SIZE_W(SW), .LINK_BPC(BPC),
                    .RT_DEPTH(DEP), .CNT_W(CW)) u0 (.*);

    int tests = 0, fails = 0;
    int ptr = 0;
    int busy [N];
    bit busy_ref [N];
    int pk [N];
    int by [N];
    bit mset [16];
    int mcnt = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        int t, e;
        bit fr, acc, rec, dup, full, hit;
        logic [N-1:0] edv;
        @(negedge clk);
        #1;
        t   = ptr;
        fr  = (busy[t] == 0);
        edv = '0;
        if (up_valid && fr) edv[t] = 1'b1;
        acc = up_valid && fr && dn_ready[t];
        e   = up_has_data ? int'(up_size) : 0;
        if (up_valid && !fr)
            check(dn_valid == '0 && !up_ready, busy_ref[t] ? "R4 R6 hold" : "R4 R7 hold",
                  int'({dn_valid, up_ready}), 0);
        else begin
            check(dn_valid == edv, "R2 R3 target", int'(dn_valid), int'(edv));
            check(up_ready == acc, "R5 ready", int'(up_ready), int'(acc));
        end
        if (up_valid && fr) check(int'(dn_size) == e && dn_id == up_id, "R2 fields", int'(dn_size), e);
        hit = rsp_valid && mset[rsp_id];
        check(rsp_hit == hit, "R9 lookup", int'(rsp_hit), int'(hit));
        rec  = acc && up_needs_rsp && !up_other_resp;
        dup  = rec && mset[up_id];
        full = rec && !dup && (mcnt == DEP);
        @(posedge clk);
        for (int l = 0; l < N; l++) begin
            if (up_valid && l == t && fr) begin
                busy[l]     = dn_ready[t] ? 1 + (e + BPC - 1) / BPC : 1;
                busy_ref[l] = !dn_ready[t];
            end else if (busy[l] > 0) busy[l]--;
        end
        if (acc) begin
            pk[t]++;
            by[t] += e;
        end
        if (up_valid) ptr = (ptr + 1) % N;
        if (hit) begin
            mset[rsp_id] = 1'b0;
            mcnt--;
        end
        if (rec && !dup && !full) begin
            mset[up_id] = 1'b1;
            mcnt++;
        end
        #1;
        check(err_dup == dup, "R10 dup pulse", int'(err_dup), int'(dup));
        check(err_full == full, "R11 full pulse", int'(err_full), int'(full));
    endtask

    task automatic idle();
        up_valid  = 1'b0;
        rsp_valid = 1'b0;
        step();
    endtask

    task automatic send(input int id, input bit nr, input bit oth, input int sz);
        while (busy[ptr] != 0) idle();
        up_valid = 1'b1; up_id = IDW'(id); up_needs_rsp = nr; up_other_resp = oth;
        up_has_data = 1'b1; up_size = SW'(sz); dn_ready = '1; rsp_valid = 1'b0;
        step();
        up_valid = 1'b0;
    endtask

    task automatic lookup(input int id);
        up_valid = 1'b0; rsp_valid = 1'b1; rsp_id = IDW'(id);
        step();
        rsp_valid = 1'b0;
    endtask

    task automatic check_stats(input string tag);
        for (int l = 0; l < N; l++) begin
            check(int'(pkt_cnt[l*CW +: CW]) == pk[l], tag, int'(pkt_cnt[l*CW +: CW]), pk[l]);
            check(int'(byte_cnt[l*CW +: CW]) == by[l], tag, int'(byte_cnt[l*CW +: CW]), by[l]);
        end
    endtask

    initial begin
        for (int l = 0; l < N; l++) begin busy[l] = 0; busy_ref[l] = 0; pk[l] = 0; by[l] = 0; end
        for (int i = 0; i < 16; i++) mset[i] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check(up_ready == 1'b0 && dn_valid == '0, "R1 idle outputs", int'(up_ready), 0);
        check(err_dup == 1'b0 && err_full == 1'b0, "R1 errors", int'({err_dup, err_full}), 0);
        check_stats("R1 counters");
        for (int i = 0; i < 16; i++) begin
            rsp_valid = 1'b1; rsp_id = IDW'(i); #1;
            check(rsp_hit == 1'b0, "R1 table empty", int'(rsp_hit), 0);
        end
        rsp_valid = 1'b0;
        // R1 R3: first offer goes to link 0, idles do not move the pointer
        idle(); idle();
        send(5, 1, 0, 8);   // R9 record
        send(5, 1, 0, 3);   // R10 duplicate
        send(6, 1, 0, 0);   // R9 record, table now full
        send(7, 1, 0, 1);   // R11 full
        send(8, 0, 0, 2);   // R9 no reply wanted
        send(9, 1, 1, 2);   // R9 answered elsewhere
        lookup(8); lookup(9); lookup(7);
        lookup(5); lookup(5);
        send(7, 1, 0, 4);   // R9 space again
        lookup(7); lookup(6);
        check_stats("R8 counters directed");
        // Sweep: all sizes, data flag, ready patterns (R4..R8)
        up_needs_rsp = 1'b0;
        for (int sz = 0; sz < 32; sz++) begin
            for (int hd = 0; hd < 2; hd++) begin
                for (int rm = 0; rm < 8; rm++) begin
                    up_valid = 1'b1; up_id = IDW'(sz); up_has_data = hd[0];
                    up_size = SW'(sz); dn_ready = N'(rm); up_other_resp = 1'b0;
                    rsp_valid = 1'b0;
                    step();
                    if ((sz + rm) % 5 == 0) idle();
                end
            end
        end
        up_valid = 1'b0;
        repeat (12) idle();
        check_stats("R8 counters sweep");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule